// File: doc/BRIEF.md
# Two-Word Burst SRAM Core with Split Read and Write Ports

This block is a synchronous on-chip SRAM core. It has one address bus, a write data port and a separate read data port. Every access moves exactly two words. The second word sits at the next address, and the address wraps at the top of the array. Double-rate traffic is folded into the core clock as two beats per cycle: beat 0 is the rising-edge word and beat 1 is the falling-edge word.

A command is sampled on the rising clock edge. An active-low load strobe qualifies the command, and a read/write select then picks the direction. Writes are late: the two data beats and their per-lane byte enables arrive in the cycle after the write command. They wait in a write buffer for one more cycle before they reach the array. A read that arrives while that buffer still holds data for one of its words takes those lanes from the buffer, so reads always return the newest data. Read data appears one cycle after the read command, marked by a valid flag. The outputs drop to zero in any cycle that does not carry read data.

The array depth must be a power of two, and the whole array is cleared by reset. Commands may follow each other in every cycle, in any mix of reads, writes and idle cycles.

Top module: `sio_burst2_sram`

## Requirements
- R1: A command is taken on a rising edge when `ld_n` is 0. `rd_wr` = 1 selects a read and `rd_wr` = 0 selects a write. A cycle with `ld_n` = 1 is idle and changes nothing, whatever `rd_wr`, `addr` and the write inputs carry.
- R2: Each access covers word `addr` (beat 0) and word (`addr`+1) modulo DEPTH (beat 1). Starting at DEPTH-1 wraps beat 1 to word 0.
- R3: Suppose a read command is sampled at edge N. After edge N+1, and only for that cycle, `rvalid` is 1 and `rdata0`/`rdata1` hold the two words.
- R4: For a write command sampled at edge N, the data beats and enables are taken at edge N+1. Whatever `wdata0`, `wdata1` and the enables carry in the command cycle has no effect.
- R5: The byte enables are active low and apply per beat. Lane l of a word is bits [9l+8:9l] (lane 0 is bits 8..0 and lane 3 is bits 35..27). A lane is written only if its enable bit is 0. All enables at 1 leave the word unchanged.
- R6: A read returns the newest data even when its words are still in the write buffer, including a read issued right after a write to the same or an overlapping address. Only lanes enabled by that write are taken from the buffer; the other lanes come from the array.
- R7: After any edge that did not sample a read one cycle earlier, `rvalid` is 0 and both read data outputs are zero.
- R8: A write whose command is followed by idle cycles or reads still completes, and its data is visible to later reads.
- R9: After reset, `rvalid` is 0 and every array word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_n | input | 1 | Command strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write (when `ld_n` = 0) |
| addr | input | clog2(DEPTH) | First word address of the burst |
| wdata0 | input | LANES*LANE_W | Write beat 0, taken the cycle after the write command |
| wdata1 | input | LANES*LANE_W | Write beat 1, taken with beat 0 |
| wben0_n | input | LANES | Active-low lane enables for beat 0 |
| wben1_n | input | LANES | Active-low lane enables for beat 1 |
| rdata0 | output | LANES*LANE_W | Read beat 0 |
| rdata1 | output | LANES*LANE_W | Read beat 1 |
| rvalid | output | 1 | Read data present in this cycle |

## Verification
Read results are due two rising edges after the read command. The command register sits at the first edge and the output register at the second. Write data is due one edge after its command. The bench drives each command on a falling edge and keeps a two-deep queue of expected read words. It compares the outputs on the falling edge of the second cycle after the command, so each comparison sees the stable value of the output register. The bench's reference memory applies a write at the moment its data is presented, before it computes a read issued in the same cycle. This is how the forwarding timing is restated without copying the buffer.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sio_op_e;

  // Strobe low qualifies the command; select picks direction.
  function automatic sio_op_e decode_op(input logic ld_n, input logic rd_wr);
    if (ld_n)
      return OP_IDLE;
    else if (rd_wr)
      return OP_READ;
    else
      return OP_WRITE;
  endfunction

endpackage

// File: rtl/sio_cmd_stage.sv
module sio_cmd_stage
  import sio_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic          rd_wr,
  input  logic [AW-1:0] addr,
  output logic          rd_go,
  output logic          wr_go,
  output logic [AW-1:0] cmd_addr
);

  sio_op_e op_now;

  always_comb op_now = decode_op(ld_n, rd_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_go    <= 1'b0;
      wr_go    <= 1'b0;
      cmd_addr <= '0;
    end else begin
      rd_go <= (op_now == OP_READ);
      wr_go <= (op_now == OP_WRITE);
      if (op_now != OP_IDLE)
        cmd_addr <= addr;
    end
  end

endmodule

// File: rtl/sio_wbuf.sv
module sio_wbuf #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int DW    = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [DW-1:0]    wdata0,
  input  logic [DW-1:0]    wdata1,
  input  logic [LANES-1:0] wben0_n,
  input  logic [LANES-1:0] wben1_n,
  output logic             wb_valid,
  output logic [AW-1:0]    wb_addr,
  output logic [DW-1:0]    wb_d0,
  output logic [DW-1:0]    wb_d1,
  output logic [LANES-1:0] wb_m0_n,
  output logic [LANES-1:0] wb_m1_n
);

  // Late-write capture: data of the command registered one edge earlier.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_d0    <= '0;
      wb_d1    <= '0;
      wb_m0_n  <= '1;
      wb_m1_n  <= '1;
    end else begin
      wb_valid <= wr_go;
      if (wr_go) begin
        wb_addr <= cmd_addr;
        wb_d0   <= wdata0;
        wb_d1   <= wdata1;
        wb_m0_n <= wben0_n;
        wb_m1_n <= wben1_n;
      end
    end
  end

endmodule

// File: rtl/sio_array.sv
module sio_array #(
  parameter int DEPTH  = 64,
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DW     = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [DW-1:0]    wd0,
  input  logic [DW-1:0]    wd1,
  input  logic [LANES-1:0] wm0_n,
  input  logic [LANES-1:0] wm1_n,
  input  logic [AW-1:0]    ra,
  output logic [DW-1:0]    rq0,
  output logic [DW-1:0]    rq1
);

  logic [DW-1:0] mem [DEPTH];

  function automatic logic [AW-1:0] burst_next(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  logic [AW-1:0] wa1;
  logic [AW-1:0] ra1;

  assign wa1 = burst_next(wa);
  assign ra1 = burst_next(ra);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= '0;
    end else if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (!wm0_n[l])
          mem[wa][l*LANE_W +: LANE_W] <= wd0[l*LANE_W +: LANE_W];
        if (!wm1_n[l])
          mem[wa1][l*LANE_W +: LANE_W] <= wd1[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rq0 = mem[ra];
  assign rq1 = mem[ra1];

endmodule

// File: rtl/sio_rd_path.sv
module sio_rd_path #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DW     = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_go,
  input  logic [AW-1:0]    rd_addr,
  input  logic [DW-1:0]    arr0,
  input  logic [DW-1:0]    arr1,
  input  logic             wb_valid,
  input  logic [AW-1:0]    wb_addr,
  input  logic [DW-1:0]    wb_d0,
  input  logic [DW-1:0]    wb_d1,
  input  logic [LANES-1:0] wb_m0_n,
  input  logic [LANES-1:0] wb_m1_n,
  output logic [DW-1:0]    rdata0,
  output logic [DW-1:0]    rdata1,
  output logic             rvalid,
  output logic             fwd_hit
);

  function automatic logic [AW-1:0] burst_next(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  logic [AW-1:0] rd_addr1;
  logic [AW-1:0] wb_addr1;
  // hit_rb: read word r matches buffered beat b
  logic hit_00, hit_01, hit_10, hit_11;
  logic [DW-1:0] word0, word1;

  assign rd_addr1 = burst_next(rd_addr);
  assign wb_addr1 = burst_next(wb_addr);

  assign hit_00 = rd_go && wb_valid && (rd_addr  == wb_addr);
  assign hit_01 = rd_go && wb_valid && (rd_addr  == wb_addr1);
  assign hit_10 = rd_go && wb_valid && (rd_addr1 == wb_addr);
  assign hit_11 = rd_go && wb_valid && (rd_addr1 == wb_addr1);
  assign fwd_hit = hit_00 | hit_01 | hit_10 | hit_11;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int LO = l * LANE_W;
    assign word0[LO +: LANE_W] =
      (hit_00 && !wb_m0_n[l]) ? wb_d0[LO +: LANE_W] :
      (hit_01 && !wb_m1_n[l]) ? wb_d1[LO +: LANE_W] :
                                arr0[LO +: LANE_W];
    assign word1[LO +: LANE_W] =
      (hit_10 && !wb_m0_n[l]) ? wb_d0[LO +: LANE_W] :
      (hit_11 && !wb_m1_n[l]) ? wb_d1[LO +: LANE_W] :
                                arr1[LO +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata0 <= '0;
      rdata1 <= '0;
    end else begin
      rvalid <= rd_go;
      rdata0 <= rd_go ? word0 : '0;
      rdata1 <= rd_go ? word1 : '0;
    end
  end

endmodule

// File: rtl/sio_burst2_sram.sv
module sio_burst2_sram #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_n,
  input  logic                      rd_wr,
  input  logic [$clog2(DEPTH)-1:0]  addr,
  input  logic [LANES*LANE_W-1:0]   wdata0,
  input  logic [LANES*LANE_W-1:0]   wdata1,
  input  logic [LANES-1:0]          wben0_n,
  input  logic [LANES-1:0]          wben1_n,
  output logic [LANES*LANE_W-1:0]   rdata0,
  output logic [LANES*LANE_W-1:0]   rdata1,
  output logic                      rvalid
);

  localparam int AW = $clog2(DEPTH);
  localparam int DW = LANES * LANE_W;

  // Named internal events, observed by the bound checker.
  logic             rd_go;
  logic             wr_go;
  logic [AW-1:0]    cmd_addr;
  logic             wb_valid;
  logic [AW-1:0]    wb_addr;
  logic [DW-1:0]    wb_d0, wb_d1;
  logic [LANES-1:0] wb_m0_n, wb_m1_n;
  logic [DW-1:0]    arr0, arr1;
  logic             fwd_hit;

  sio_cmd_stage #(.AW(AW)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_n     (ld_n),
    .rd_wr    (rd_wr),
    .addr     (addr),
    .rd_go    (rd_go),
    .wr_go    (wr_go),
    .cmd_addr (cmd_addr)
  );

  sio_wbuf #(.AW(AW), .LANES(LANES), .DW(DW)) u_wbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_go    (wr_go),
    .cmd_addr (cmd_addr),
    .wdata0   (wdata0),
    .wdata1   (wdata1),
    .wben0_n  (wben0_n),
    .wben1_n  (wben1_n),
    .wb_valid (wb_valid),
    .wb_addr  (wb_addr),
    .wb_d0    (wb_d0),
    .wb_d1    (wb_d1),
    .wb_m0_n  (wb_m0_n),
    .wb_m1_n  (wb_m1_n)
  );

  sio_array #(
    .DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W), .DW(DW)
  ) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wb_valid),
    .wa    (wb_addr),
    .wd0   (wb_d0),
    .wd1   (wb_d1),
    .wm0_n (wb_m0_n),
    .wm1_n (wb_m1_n),
    .ra    (cmd_addr),
    .rq0   (arr0),
    .rq1   (arr1)
  );

  sio_rd_path #(
    .AW(AW), .LANES(LANES), .LANE_W(LANE_W), .DW(DW)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_go    (rd_go),
    .rd_addr  (cmd_addr),
    .arr0     (arr0),
    .arr1     (arr1),
    .wb_valid (wb_valid),
    .wb_addr  (wb_addr),
    .wb_d0    (wb_d0),
    .wb_d1    (wb_d1),
    .wb_m0_n  (wb_m0_n),
    .wb_m1_n  (wb_m1_n),
    .rdata0   (rdata0),
    .rdata1   (rdata1),
    .rvalid   (rvalid),
    .fwd_hit  (fwd_hit)
  );

endmodule

// File: rtl/sio_burst2_sram_chk.sv
module sio_burst2_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_n,
  input logic          rd_wr,
  input logic          rvalid,
  input logic [DW-1:0] rdata0,
  input logic [DW-1:0] rdata1,
  input logic          rd_go,
  input logic          wr_go,
  input logic          wb_valid,
  input logic          fwd_hit
);

  p_read_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_n && rd_wr) |=> (rd_go && !wr_go));

  p_write_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_n && !rd_wr) |=> (wr_go && !rd_go));

  p_idle_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> (!rd_go && !wr_go));

  p_one_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_go, wr_go}));

  p_read_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rvalid);

  p_quiet_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> (!rvalid && rdata0 == '0 && rdata1 == '0));

  p_late_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> wb_valid);

  p_fwd_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> (wb_valid && rd_go));

endmodule

bind sio_burst2_sram sio_burst2_sram_chk #(.DW(LANES*LANE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ld_n     (ld_n),
  .rd_wr    (rd_wr),
  .rvalid   (rvalid),
  .rdata0   (rdata0),
  .rdata1   (rdata1),
  .rd_go    (rd_go),
  .wr_go    (wr_go),
  .wb_valid (wb_valid),
  .fwd_hit  (fwd_hit)
);

// File: tb/sio_burst2_sram_test.sv
module sio_burst2_sram_test;

  localparam int DEPTH  = 64;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;
  localparam int AW     = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic             ld_n;
  logic             rd_wr;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    wdata0, wdata1;
  logic [LANES-1:0] wben0_n, wben1_n;
  logic [DW-1:0]    rdata0, rdata1;
  logic             rvalid;

  sio_burst2_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) uut (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rd_wr(rd_wr), .addr(addr),
    .wdata0(wdata0), .wdata1(wdata1), .wben0_n(wben0_n), .wben1_n(wben1_n),
    .rdata0(rdata0), .rdata1(rdata1), .rvalid(rvalid)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int junk    = 0;

  logic [DW-1:0] ref_mem [DEPTH];

  // data staged by the caller for a write command, and data owed this cycle
  logic [DW-1:0]    nx_d0, nx_d1, pd_d0, pd_d1;
  logic [LANES-1:0] nx_m0, nx_m1, pd_m0, pd_m1;
  logic [AW-1:0]    pd_a;
  bit               pd_wr = 1'b0;

  // two-deep queue of expected reads
  bit            e_rd  [2];
  logic [DW-1:0] e_q0  [2];
  logic [DW-1:0] e_q1  [2];
  string         e_tag [2];

  function automatic logic [DW-1:0] pattern(input int a, input int salt);
    longint v;
    v = (longint'(a) + 1) * 64'h3_1C5A_7E93 + longint'(salt) * 64'h9_E377_9B97;
    return v[DW-1:0] ^ {v[DW-19:0], v[DW-1:DW-18]};
  endfunction

  function automatic logic [DW-1:0] apply_lanes(input logic [DW-1:0] old_w,
                                                input logic [DW-1:0] new_w,
                                                input logic [LANES-1:0] en_n);
    logic [DW-1:0] r;
    r = old_w;
    for (int l = 0; l < LANES; l++)
      if (en_n[l] == 1'b0)
        r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
    return r;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One core cycle: compare outputs owed from two commands ago, then drive.
  task automatic step(input bit is_ld, input bit is_rd, input logic [AW-1:0] a,
                      input string tag);
    @(negedge clk);
    if (e_rd[1]) begin
      check({e_tag[1], " rvalid"}, DW'(rvalid), DW'(1));
      check({e_tag[1], " beat0"}, rdata0, e_q0[1]);
      check({e_tag[1], " beat1"}, rdata1, e_q1[1]);
    end else begin
      check("R7 rvalid idle", DW'(rvalid), '0);
      check("R7 rdata idle", rdata0 | rdata1, '0);
    end
    ld_n  = !is_ld;
    rd_wr = is_rd;
    addr  = a;
    if (pd_wr) begin
      wdata0  = pd_d0;  wdata1  = pd_d1;
      wben0_n = pd_m0;  wben1_n = pd_m1;
      ref_mem[pd_a] = apply_lanes(ref_mem[pd_a], pd_d0, pd_m0);
      ref_mem[(int'(pd_a) + 1) % DEPTH] =
        apply_lanes(ref_mem[(int'(pd_a) + 1) % DEPTH], pd_d1, pd_m1);
    end else begin
      // R4: stray data with every lane enabled must be ignored
      junk++;
      wdata0  = pattern(junk, 77);
      wdata1  = pattern(junk, 78);
      wben0_n = '0;
      wben1_n = '0;
    end
    e_rd[1]  = e_rd[0];  e_q0[1] = e_q0[0];  e_q1[1] = e_q1[0];  e_tag[1] = e_tag[0];
    e_rd[0]  = is_ld && is_rd;
    e_tag[0] = tag;
    if (is_ld && is_rd) begin
      e_q0[0] = ref_mem[a];
      e_q1[0] = ref_mem[(int'(a) + 1) % DEPTH];
    end
    pd_wr = is_ld && !is_rd;
    if (pd_wr) begin
      pd_a = a;
      pd_d0 = nx_d0; pd_d1 = nx_d1; pd_m0 = nx_m0; pd_m1 = nx_m1;
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d0,
                          input logic [DW-1:0] d1, input logic [LANES-1:0] m0,
                          input logic [LANES-1:0] m1);
    nx_d0 = d0; nx_d1 = d1; nx_m0 = m0; nx_m1 = m1;
    step(1'b1, 1'b0, a, "write");
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag);
    step(1'b1, 1'b1, a, tag);
  endtask

  task automatic do_idle(input bit sel);
    step(1'b0, sel, AW'(junk), "idle");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got no end expected end");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    for (int k = 0; k < 2; k++) begin e_rd[k] = 1'b0; e_tag[k] = ""; end
    rst_n = 1'b0; ld_n = 1'b1; rd_wr = 1'b0; addr = '0;
    wdata0 = '0; wdata1 = '0; wben0_n = '1; wben1_n = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R9 rvalid after reset", DW'(rvalid), '0);

    // R9: cleared array, including the wrap word
    do_read(AW'(5), "R9");
    do_read(AW'(DEPTH - 1), "R9");
    do_idle(1'b1);

    // R2: fill by even addresses, read every start address (wrap at top)
    for (int a = 0; a < DEPTH; a += 2)
      do_write(AW'(a), pattern(a, 1), pattern(a + 1, 1), '0, '0);
    for (int a = 0; a < DEPTH; a++)
      do_read(AW'(a), "R2");
    do_idle(1'b0);

    // R3: scattered back-to-back reads
    do_read(AW'(17), "R3");
    do_read(AW'(3), "R3");
    do_read(AW'(42), "R3");
    do_idle(1'b1);

    // R5 and R6: every lane mask, read at once (buffered) and later (array)
    for (int m = 0; m < 16; m++) begin
      do_write(AW'(20), pattern(m, 2), pattern(m, 3), 4'(m), ~4'(m));
      do_read(AW'(20), "R6 same-address");
      do_read(AW'(19), "R6 overlap-low");
      do_read(AW'(21), "R5 after commit");
    end
    do_write(AW'(20), pattern(9, 4), pattern(9, 5), 4'hF, 4'hF);
    do_read(AW'(20), "R5 all-high");
    do_write(AW'(21), pattern(8, 4), pattern(8, 5), 4'h0, 4'h0);
    do_read(AW'(20), "R6 overlap-high");
    do_idle(1'b0);

    // R4: command-cycle data ignored
    do_write(AW'(40), pattern(40, 9), pattern(41, 9), 4'h0, 4'h0);
    do_read(AW'(40), "R4");
    do_write(AW'(DEPTH - 1), pattern(63, 9), pattern(0, 9), 4'h0, 4'h0);
    do_read(AW'(DEPTH - 1), "R2 wrap write");

    // R8: write followed by idle cycles still lands
    do_write(AW'(50), pattern(50, 6), pattern(51, 6), 4'h0, 4'h5);
    do_idle(1'b0);
    do_idle(1'b1);
    do_read(AW'(50), "R8");

    // R1: idle cycles with write select and enables low change nothing
    step(1'b0, 1'b0, AW'(44), "idle");
    step(1'b0, 1'b0, AW'(44), "idle");
    do_read(AW'(44), "R1");
    do_idle(1'b0);
    do_idle(1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule